// File: doc/BRIEF.md
# Daisy-Chain Write Command Frame Encoder

This block turns one register write for a chain of battery-monitor devices into a 32-bit command word and sends it out serially. The caller presents a chain position, a register number, a data byte and a broadcast flag, then pulses `start_i`. The block packs the fields. It appends an 8-bit CRC over the header and a fixed three-bit tail. It then shifts the word out most significant bit first as a mode-1 SPI master: the serial clock idles low, data changes on the rising edge, and the receiver samples on the falling edge.

The serial clock is derived from the system clock by a plain half-period divider. Chip select stays low for the whole 32-bit frame. After the last falling edge it is held low for one more half period before it is released. A single-cycle `done_o` pulse marks the release. Devices in the chain take their address least significant bit first, so by default the block bit-reverses the chain position before packing it.

Top module: `chain_cmd_tx`

## Requirements
- R1: The transmitted word carries the register number in bits 26:21, the data byte in bits 20:13, the broadcast flag in bit 12, and a zero in bit 11.
- R2: Bits 10:3 hold the remainder of the 21-bit value in bits 31:11, taken modulo x^8+x^5+x^3+x^2+x+1 (0x2F with the x^8 term implicit). This equals two byte steps over the top two header bytes, followed by a plain XOR of the low byte.
- R3: Bits 2:0 of every word are binary 010.
- R4: While chip select is high the serial clock is low. The data line changes only on a rising serial clock edge, so it is stable across each falling edge.
- R5: Each serial clock level lasts exactly HALF_DIV system clock cycles, and the first rising edge comes HALF_DIV cycles after chip select falls.
- R6: A frame carries exactly 32 rising serial clock edges, sent most significant bit first, and chip select is low only while `busy_o` is high.
- R7: `done_o` is high for exactly one cycle, in the cycle in which chip select returns high. `busy_o` is low from that cycle on.
- R8: A `start_i` pulse that arrives while a frame is in flight is ignored. The frame in flight is unchanged, and no second frame follows.
- R9: In reset and after it, chip select is high, and the serial clock, data line, `busy_o` and `done_o` are low.
- R10: With ADDR_REVERSE=1, bits 31:27 hold the device address bit-reversed: `dev_addr_i[0]` lands in bit 31 and `dev_addr_i[4]` in bit 27.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request to send one frame; taken only while idle |
| dev_addr_i | input | 5 | Chain position of the target device |
| reg_addr_i | input | 6 | Register number in the target device |
| data_i | input | 8 | Byte to be written |
| bcast_i | input | 1 | Write to every device in the chain |
| busy_o | output | 1 | Frame in flight |
| done_o | output | 1 | One-cycle pulse at the end of a frame |
| sclk_o | output | 1 | Serial clock, idles low |
| cs_n_o | output | 1 | Active-low chip select |
| mosi_o | output | 1 | Serial data out |

## Verification
The bench builds the block with HALF_DIV=3 and ADDR_REVERSE=1. With these values every serial clock level lasts several system cycles, so the bench can check both the half-period length and the stability of the data line across each falling edge. The reversal path is also active. A model receiver rebuilds each frame and compares it with a word computed by long division in the bench. The stimulus includes the all-ones broadcast address, whose result is known in advance, single-bit addresses that expose the reversal, and a second start issued in the middle of a frame.

// File: rtl/cmd_pkg.sv
package cmd_pkg;
  localparam int WORD_W   = 32;
  localparam int DEV_W    = 5;
  localparam int REG_W    = 6;
  localparam int DATA_W   = 8;
  localparam int CRC_W    = 8;
  localparam int HDR_W    = DEV_W + REG_W + DATA_W + 2;
  localparam int TAIL_W   = WORD_W - HDR_W - CRC_W;
  localparam logic [CRC_W-1:0]  CRC_POLY = 8'h2F;
  localparam logic [TAIL_W-1:0] TAIL_BITS = 3'b010;

  typedef enum logic [1:0] {
    SER_IDLE  = 2'd0,
    SER_SHIFT = 2'd1,
    SER_HOLD  = 2'd2
  } ser_state_t;
endpackage

// File: rtl/cmd_rst_sync.sv
module cmd_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmd_crc_step.sv
module cmd_crc_step
  import cmd_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = CRC_POLY
) (
  input  logic [CRC_W-1:0] byte_i,
  output logic [CRC_W-1:0] crc_o
);
  logic [CRC_W-1:0] stage [0:CRC_W];

  assign stage[0] = byte_i;

  generate
    for (genvar i = 0; i < CRC_W; i++) begin : g_bit
      assign stage[i+1] = stage[i][CRC_W-1]
                        ? ({stage[i][CRC_W-2:0], 1'b0} ^ POLY)
                        :  {stage[i][CRC_W-2:0], 1'b0};
    end
  endgenerate

  assign crc_o = stage[CRC_W];
endmodule

// File: rtl/cmd_pack.sv
module cmd_pack
  import cmd_pkg::*;
#(
  parameter bit ADDR_REVERSE = 1'b1
) (
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [REG_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bcast_i,
  output logic [WORD_W-1:0] word_o
);
  localparam int PAD_W = 3*CRC_W - HDR_W;

  logic [DEV_W-1:0]   dev_field;
  logic [HDR_W-1:0]   header;
  logic [3*CRC_W-1:0] crc_in;
  logic [CRC_W-1:0]   crc_hi, crc_mid_in, crc_mid, crc_val;

  generate
    if (ADDR_REVERSE) begin : g_rev
      for (genvar i = 0; i < DEV_W; i++) begin : g_bit
        assign dev_field[i] = dev_addr_i[DEV_W-1-i];
      end
    end else begin : g_direct
      assign dev_field = dev_addr_i;
    end
  endgenerate

  assign header = {dev_field, reg_addr_i, data_i, bcast_i, 1'b0};
  assign crc_in = {{PAD_W{1'b0}}, header};

  cmd_crc_step u_step_hi (
    .byte_i (crc_in[3*CRC_W-1:2*CRC_W]),
    .crc_o  (crc_hi)
  );

  assign crc_mid_in = crc_hi ^ crc_in[2*CRC_W-1:CRC_W];

  cmd_crc_step u_step_mid (
    .byte_i (crc_mid_in),
    .crc_o  (crc_mid)
  );

  assign crc_val = crc_mid ^ crc_in[CRC_W-1:0];
  assign word_o  = {header, crc_val, TAIL_BITS};
endmodule

// File: rtl/cmd_serial.sv
module cmd_serial
  import cmd_pkg::*;
#(
  parameter int HALF_DIV = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [WORD_W-1:0] word_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o
);
  localparam int DIV_W = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int BIT_W = $clog2(WORD_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(HALF_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(WORD_W - 1);

  ser_state_t        state_q, state_d;
  logic [DIV_W-1:0]  div_q, div_d;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [WORD_W-1:0] sreg_q, sreg_d;
  logic              sclk_q, sclk_d;
  logic              mosi_q, mosi_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic              tick;
  logic              load_en, shift_en;

  assign tick = (div_q == DIV_LAST);

  always_comb begin
    state_d  = state_q;
    div_d    = div_q;
    bit_d    = bit_q;
    sreg_d   = sreg_q;
    sclk_d   = sclk_q;
    mosi_d   = mosi_q;
    cs_n_d   = cs_n_q;
    done_d   = 1'b0;
    load_en  = 1'b0;
    shift_en = 1'b0;
    unique case (state_q)
      SER_IDLE: begin
        div_d = '0;
        if (start_i) begin
          load_en = 1'b1;
          state_d = SER_SHIFT;
          cs_n_d  = 1'b0;
          bit_d   = '0;
        end
      end
      SER_SHIFT: begin
        div_d = tick ? '0 : div_q + 1'b1;
        if (tick) begin
          if (!sclk_q) begin
            shift_en = 1'b1;
            sclk_d   = 1'b1;
          end else begin
            sclk_d = 1'b0;
            bit_d  = bit_q + 1'b1;
            if (bit_q == BIT_LAST) state_d = SER_HOLD;
          end
        end
      end
      SER_HOLD: begin
        div_d = tick ? '0 : div_q + 1'b1;
        if (tick) begin
          state_d = SER_IDLE;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: begin
        state_d = SER_IDLE;
        cs_n_d  = 1'b1;
        sclk_d  = 1'b0;
      end
    endcase
    if (load_en) begin
      sreg_d = word_i;
    end else if (shift_en) begin
      mosi_d = sreg_q[WORD_W-1];
      sreg_d = {sreg_q[WORD_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SER_IDLE;
      div_q   <= '0;
      bit_q   <= '0;
      sreg_q  <= '0;
      sclk_q  <= 1'b0;
      mosi_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      div_q   <= div_d;
      bit_q   <= bit_d;
      sreg_q  <= sreg_d;
      sclk_q  <= sclk_d;
      mosi_q  <= mosi_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
    end
  end

  assign busy_o = (state_q != SER_IDLE);
  assign done_o = done_q;
  assign sclk_o = sclk_q;
  assign cs_n_o = cs_n_q;
  assign mosi_o = mosi_q;
endmodule

// File: rtl/chain_cmd_tx.sv
module chain_cmd_tx
  import cmd_pkg::*;
#(
  parameter int HALF_DIV     = 36,
  parameter bit ADDR_REVERSE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [DEV_W-1:0]  dev_addr_i,
  input  logic [REG_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              bcast_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              sclk_o,
  output logic              cs_n_o,
  output logic              mosi_o
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] word;

  cmd_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmd_pack #(.ADDR_REVERSE(ADDR_REVERSE)) u_pack (
    .dev_addr_i (dev_addr_i),
    .reg_addr_i (reg_addr_i),
    .data_i     (data_i),
    .bcast_i    (bcast_i),
    .word_o     (word)
  );

  cmd_serial #(.HALF_DIV(HALF_DIV)) u_ser (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .start_i (start_i),
    .word_i  (word),
    .busy_o  (busy_o),
    .done_o  (done_o),
    .sclk_o  (sclk_o),
    .cs_n_o  (cs_n_o),
    .mosi_o  (mosi_o)
  );
endmodule

// File: rtl/chain_cmd_tx_chk.sv
module chain_cmd_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic sclk_o,
  input logic cs_n_o,
  input logic mosi_o
);
  logic [6:0] rise_cnt;
  logic       sclk_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_cnt  <= '0;
      sclk_prev <= 1'b0;
    end else begin
      sclk_prev <= sclk_o;
      if (cs_n_o)                     rise_cnt <= '0;
      else if (sclk_o && !sclk_prev)  rise_cnt <= rise_cnt + 1'b1;
    end
  end

  AST_IDLE_SCLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o); // R4
  AST_MOSI_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(mosi_o) |-> $rose(sclk_o)); // R4
  AST_EDGE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_n_o) |-> (rise_cnt == 7'd32)); // R6
  AST_CS_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n_o |-> busy_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> ($rose(cs_n_o) && !busy_o)); // R7
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i) |=> !$fell(cs_n_o)); // R8
endmodule

bind chain_cmd_tx chain_cmd_tx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start_i (start_i),
  .busy_o  (busy_o),
  .done_o  (done_o),
  .sclk_o  (sclk_o),
  .cs_n_o  (cs_n_o),
  .mosi_o  (mosi_o)
);

// File: tb/chain_cmd_tx_test.sv
module chain_cmd_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 3;

  logic       clk, rst_n, start_i, bcast_i;
  logic [4:0] dev_addr_i;
  logic [5:0] reg_addr_i;
  logic [7:0] data_i;
  logic       busy_o, done_o, sclk_o, cs_n_o, mosi_o;

  int checks = 0;
  int errors = 0;

  // receiver model state
  logic [31:0] cap;
  int  rise_cnt, frame_cnt, gap;
  logic prev_sclk, prev_cs, mosi_at_rise, mosi_bad, period_bad;

  chain_cmd_tx #(.HALF_DIV(HALF), .ADDR_REVERSE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .dev_addr_i(dev_addr_i), .reg_addr_i(reg_addr_i), .data_i(data_i),
    .bcast_i(bcast_i), .busy_o(busy_o), .done_o(done_o),
    .sclk_o(sclk_o), .cs_n_o(cs_n_o), .mosi_o(mosi_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_word(input logic [4:0] dev, input logic [5:0] ra,
                                           input logic [7:0] d, input logic bc);
    logic [4:0]  rdev;
    logic [20:0] hdr;
    logic [7:0]  r;
    logic        fb;
    for (int i = 0; i < 5; i++) rdev[i] = dev[4-i];
    hdr = {rdev, ra, d, bc, 1'b0};
    r = 8'h00;
    for (int i = 20; i >= 0; i--) begin
      fb = r[7];
      r  = {r[6:0], hdr[i]};
      if (fb) r = r ^ 8'h2F;
    end
    return {hdr, r, 3'b010};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_n) begin
      rise_cnt = 0; frame_cnt = 0; gap = 0;
      prev_sclk = 1'b0; prev_cs = 1'b1;
      mosi_bad = 1'b0; period_bad = 1'b0; cap = '0; mosi_at_rise = 1'b0;
    end else begin
      if (!cs_n_o) begin
        if (prev_cs) begin
          gap = 0; rise_cnt = 0; frame_cnt++;
        end else gap++;
        if (sclk_o != prev_sclk) begin
          if (gap != HALF) period_bad = 1'b1;
          gap = 0;
          if (sclk_o) begin
            rise_cnt++;
            mosi_at_rise = mosi_o;
          end else begin
            if (mosi_o != mosi_at_rise) mosi_bad = 1'b1;
            cap = {cap[30:0], mosi_o};
          end
        end
      end else if (sclk_o) begin
        mosi_bad = 1'b1;
      end
      prev_sclk = sclk_o;
      prev_cs   = cs_n_o;
    end
  end

  task automatic send(input logic [4:0] dev, input logic [5:0] ra,
                      input logic [7:0] d, input logic bc, input bit mid_start);
    int start_frames;
    logic [31:0] e;
    e = exp_word(dev, ra, d, bc);
    start_frames = frame_cnt;
    mosi_bad = 1'b0; period_bad = 1'b0;
    @(negedge clk);
    dev_addr_i = dev; reg_addr_i = ra; data_i = d; bcast_i = bc; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (mid_start) begin
      repeat (40) @(negedge clk);
      dev_addr_i = ~dev; reg_addr_i = ~ra; data_i = ~d; bcast_i = ~bc; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (!done_o) @(negedge clk);
    check(cs_n_o == 1'b1 && busy_o == 1'b0, "R7 release with done", {30'd0, cs_n_o, busy_o}, 32'h2);
    @(negedge clk);
    check(done_o == 1'b0, "R7 done one cycle", {31'd0, done_o}, 32'd0);
    check(cap == e, "R2 frame word", cap, e);
    check(rise_cnt == 32, "R6 rising edges per frame", rise_cnt, 32);
    check(!mosi_bad, "R4 data stable across falling edge", {31'd0, mosi_bad}, 32'd0);
    check(!period_bad, "R5 half period length", {31'd0, period_bad}, 32'd0);
    repeat (2 * HALF + 4) @(negedge clk);
    check(frame_cnt == start_frames + 1, mid_start ? "R8 no extra frame" : "R6 one frame",
          frame_cnt, start_frames + 1);
  endtask

  initial begin
    start_i = 1'b0; dev_addr_i = '0; reg_addr_i = '0; data_i = '0; bcast_i = 1'b0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(cs_n_o && !sclk_o && !mosi_o && !busy_o && !done_o, "R9 reset state",
          {27'd0, cs_n_o, sclk_o, mosi_o, busy_o, done_o}, 32'h10);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(cs_n_o && !sclk_o && !mosi_o && !busy_o && !done_o, "R9 after reset",
          {27'd0, cs_n_o, sclk_o, mosi_o, busy_o, done_o}, 32'h10);

    // known broadcast-address read filler word
    send(5'h1F, 6'h00, 8'h00, 1'b0, 1'b0);
    check(cap == 32'hF800030A, "R2 known vector", cap, 32'hF800030A);

    // R10 reversal: lowest address bit lands in bit 31
    send(5'b00001, 6'h00, 8'h00, 1'b0, 1'b0);
    check(cap[31:27] == 5'b10000, "R10 address reversal low bit", {27'd0, cap[31:27]}, 32'h10);
    send(5'b10110, 6'h00, 8'h00, 1'b0, 1'b0);
    check(cap[31:27] == 5'b01101, "R10 address reversal pattern", {27'd0, cap[31:27]}, 32'h0D);

    // R1 field positions
    send(5'h00, 6'h3F, 8'hA5, 1'b1, 1'b0);
    check(cap[26:21] == 6'h3F && cap[20:13] == 8'hA5 && cap[12] && !cap[11],
          "R1 field positions", {12'd0, cap[26:11]}, {12'd0, 6'h3F, 8'hA5, 2'b10});
    check(cap[2:0] == 3'b010, "R3 tail bits", {29'd0, cap[2:0]}, 32'd2);

    send(5'h1F, 6'h3F, 8'hFF, 1'b1, 1'b0);
    check(cap[2:0] == 3'b010, "R3 tail bits all ones", {29'd0, cap[2:0]}, 32'd2);

    // R8 start during a frame
    send(5'h05, 6'h14, 8'h3C, 1'b0, 1'b1);

    // random frames
    for (int n = 0; n < 30; n++) begin
      send(5'($urandom), 6'($urandom), 8'($urandom), 1'($urandom), (n % 7) == 3);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule